// File: doc/BRIEF.md
# Timer Compare Channel with Cross-Domain Operand Update

This block is one 16-bit timer channel whose compare operand can be rewritten from the processor side while the counter keeps running. The processor bus and the timer run on independent clocks. A written value is parked in a staging register on the bus side. A toggle request is then handed to the timer clock domain through a two-flop synchronizer, and the timer side returns an acknowledge toggle through a second two-flop synchronizer.

The channel mode decides when the comparator sees the new value. In the direct-takeover modes the operand is replaced as soon as the request arrives in the timer domain. In the two deferred modes the value is held as pending and is copied in only when the counter returns to zero. Because the handoff takes several timer cycles, a count that meets the old operand inside that window still raises the match flag.

A second write issued before the first has been acknowledged stalls the bus through a wait request. The match flag lives in the timer domain. It is cleared by a write-one pulse from the bus side that crosses the same kind of synchronizer.

Top module: `tmr_cmp_sync`

## Requirements
- R1: After reset the counter reads 0, the compare operand reads 0xFFFF, the match flag is 0 and the wait request is 0.
- R2: In mode 0 (free counting) the counter advances by one on every timer clock edge where cnt_en is high, and it holds when cnt_en is low.
- R3: In modes 0 (free), 1 (event count), 2 (single shot), 3 (interval), 6 and 7, a write replaces the compare operand within 4 x Tper/Tcpu + 3 bus clock cycles after the bus edge that accepts it, whether or not cnt_en is active.
- R4: In modes 4 (pulse-width) and 5 (triggered), a written value does not reach the compare operand until the counter returns to zero, either by wrapping from 0xFFFF or by a trigger restart.
- R5: In mode 3 a counting edge that finds the counter equal to the operand clears the counter to zero on that edge.
- R6: In mode 2 the counter stays idle until a start pulse. A start clears the counter and begins counting. A match returns the counter to zero and halts it.
- R7: A counting edge with the counter equal to the current operand sets the match flag. This includes an old operand that is still in place while a newer write is in transit.
- R8: A one-cycle flag_clr pulse on the bus side clears the match flag after synchronization. A set and a clear in the same timer cycle leave the flag set.
- R9: A write presented while an earlier write is still unacknowledged raises bus_wait in that same bus cycle. bus_wait stays high until the acknowledge returns, and the held write is then accepted and takes effect.
- R10: In mode 5 a start pulse restarts the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Bus-side clock |
| cpu_rst_n | input | 1 | Bus-side asynchronous active-low reset |
| cmp_wr | input | 1 | Compare write request, held while bus_wait is high |
| cmp_wdata | input | 16 | Compare value to write |
| flag_clr | input | 1 | Write-one pulse that clears the match flag |
| bus_wait | output | 1 | Stall request for a write that cannot be accepted yet |
| per_clk | input | 1 | Timer-side clock |
| per_rst_n | input | 1 | Timer-side asynchronous active-low reset |
| mode | input | 3 | Channel mode, encoded as listed in the requirements |
| cnt_en | input | 1 | Count enable or event strobe, sampled on per_clk |
| start | input | 1 | Start pulse (mode 2) or restart trigger (mode 5) |
| count | output | 16 | Current counter value |
| cmp_cur | output | 16 | Operand currently seen by the comparator |
| match_flag | output | 1 | Compare-match interrupt flag |

## Verification
Operand updates are driven at two timer-to-bus clock ratios with counting stopped, and the latency is compared against the ratio-dependent bound. A write is landed while an event-driven counter sits on the old operand, which shows whether the old value can still match during the handoff. The same sequence then confirms that the new operand governs once it is in place. Deferred modes are held for many cycles without a zero crossing and then restarted, which separates direct takeover from reload-point takeover. Back-to-back writes, interval wrap-around and single-shot halting cover the stall and the counter variants.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    MD_FREE     = 3'd0,
    MD_EVENT    = 3'd1,
    MD_ONESHOT  = 3'd2,
    MD_INTERVAL = 3'd3,
    MD_PWM      = 3'd4,
    MD_TRIG     = 3'd5,
    MD_RSV6     = 3'd6,
    MD_RSV7     = 3'd7
  } tcs_mode_e;

  function automatic logic is_reload(input tcs_mode_e m);
    return (m == MD_PWM) || (m == MD_TRIG);
  endfunction
endpackage

// File: rtl/tcs_sync2.sv
module tcs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= 1'b0;
      q    <= 1'b0;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/tcs_cpu_port.sv
module tcs_cpu_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic          ack_s,
  output logic [DW-1:0] stage,
  output logic          req_tgl,
  output logic          clr_tgl,
  output logic          bus_wait
);
  logic          busy;
  logic          accept;
  logic [DW-1:0] stage_n;
  logic          req_n;
  logic          clr_n;

  assign busy     = req_tgl ^ ack_s;
  assign accept   = wr & ~busy;
  assign bus_wait = wr & busy;

  always_comb begin
    stage_n = stage;
    req_n   = req_tgl;
    clr_n   = clr_tgl;
    if (accept) begin
      stage_n = wdata;
      req_n   = ~req_tgl;
    end
    if (clr) begin
      clr_n = ~clr_tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= '0;
      req_tgl <= 1'b0;
      clr_tgl <= 1'b0;
    end else begin
      stage   <= stage_n;
      req_tgl <= req_n;
      clr_tgl <= clr_n;
    end
  end

  AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(stage)); // R9

  AST_WAIT_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> (req_tgl == $past(req_tgl))); // R9
endmodule

// File: rtl/tcs_counter.sv
module tcs_counter
  import tcs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tcs_mode_e     md,
  input  logic          cnt_en,
  input  logic          start,
  input  logic          hit,
  output logic [DW-1:0] cnt,
  output logic          tick,
  output logic          reload_pt
);
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW-1:0] CNT_TOP = '1;

  logic          run;
  logic          run_n;
  logic [DW-1:0] cnt_n;
  logic          restart;

  assign restart   = start & ((md == MD_ONESHOT) | (md == MD_TRIG));
  assign tick      = cnt_en & ~restart & ((md != MD_ONESHOT) | run);
  assign reload_pt = (tick & (cnt == CNT_TOP)) | (restart & (md == MD_TRIG));

  always_comb begin
    cnt_n = cnt;
    run_n = run;
    if (restart) begin
      cnt_n = '0;
      run_n = (md == MD_ONESHOT);
    end else if (tick) begin
      if (hit && (md == MD_INTERVAL || md == MD_ONESHOT)) begin
        cnt_n = '0;
        if (md == MD_ONESHOT) begin
          run_n = 1'b0;
        end
      end else begin
        cnt_n = cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      cnt <= cnt_n;
      run <= run_n;
    end
  end

  AST_INTV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_INTERVAL && tick && hit) |=> (cnt == '0)); // R5

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_ONESHOT && tick && hit && !start) |=> (!run && cnt == '0)); // R6
endmodule

// File: rtl/tcs_cmp_unit.sv
module tcs_cmp_unit
  import tcs_pkg::*;
#(
  parameter int              DW      = 16,
  parameter logic [DW-1:0]   RST_CMP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tcs_mode_e     md,
  input  logic [DW-1:0] stage,
  input  logic          req_s,
  input  logic          clr_s,
  input  logic [DW-1:0] cnt,
  input  logic          tick,
  input  logic          reload_pt,
  output logic [DW-1:0] active,
  output logic          hit,
  output logic          flag,
  output logic          ack_tgl
);
  logic [DW-1:0] active_n;
  logic [DW-1:0] pend;
  logic [DW-1:0] pend_n;
  logic          pend_vld;
  logic          pend_vld_n;
  logic          ack_n;
  logic          clr_seen;
  logic          take;
  logic          clr_pulse;
  logic          flag_n;
  logic          defer;

  assign take      = req_s ^ ack_tgl;
  assign clr_pulse = clr_s ^ clr_seen;
  assign defer     = is_reload(md);
  assign hit       = tick & (cnt == active);

  always_comb begin
    active_n   = active;
    pend_n     = pend;
    pend_vld_n = pend_vld;
    ack_n      = ack_tgl;
    if (take) begin
      ack_n = req_s;
    end
    if (!defer) begin
      pend_vld_n = 1'b0;
      if (take) begin
        active_n = stage;
      end
    end else begin
      if (take) begin
        pend_n     = stage;
        pend_vld_n = 1'b1;
      end
      if (reload_pt && (take || pend_vld)) begin
        active_n   = take ? stage : pend;
        pend_vld_n = 1'b0;
      end
    end
  end

  always_comb begin
    flag_n = flag;
    if (hit) begin
      flag_n = 1'b1;
    end else if (clr_pulse) begin
      flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= RST_CMP;
      pend     <= '0;
      pend_vld <= 1'b0;
      ack_tgl  <= 1'b0;
      clr_seen <= 1'b0;
      flag     <= 1'b0;
    end else begin
      active   <= active_n;
      pend     <= pend_n;
      pend_vld <= pend_vld_n;
      ack_tgl  <= ack_n;
      clr_seen <= clr_s;
      flag     <= flag_n;
    end
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R7

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (defer && !reload_pt) |=> $stable(active)); // R4

  AST_CLR_ONLY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !$past(hit)); // R8
endmodule

// File: rtl/tmr_cmp_sync.sv
module tmr_cmp_sync
  import tcs_pkg::*;
#(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] RST_CMP = '1
) (
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic          cmp_wr,
  input  logic [DW-1:0] cmp_wdata,
  input  logic          flag_clr,
  output logic          bus_wait,
  input  logic          per_clk,
  input  logic          per_rst_n,
  input  logic [2:0]    mode,
  input  logic          cnt_en,
  input  logic          start,
  output logic [DW-1:0] count,
  output logic [DW-1:0] cmp_cur,
  output logic          match_flag
);
  tcs_mode_e     md;
  logic [DW-1:0] stage;
  logic          req_tgl;
  logic          clr_tgl;
  logic          req_s;
  logic          clr_s;
  logic          ack_tgl;
  logic          ack_s;
  logic          tick;
  logic          reload_pt;
  logic          hit;

  assign md = tcs_mode_e'(mode);

  tcs_cpu_port #(.DW(DW)) u_cpu (
    .clk      (cpu_clk),
    .rst_n    (cpu_rst_n),
    .wr       (cmp_wr),
    .wdata    (cmp_wdata),
    .clr      (flag_clr),
    .ack_s    (ack_s),
    .stage    (stage),
    .req_tgl  (req_tgl),
    .clr_tgl  (clr_tgl),
    .bus_wait (bus_wait)
  );

  tcs_sync2 u_req_sync (.clk(per_clk), .rst_n(per_rst_n), .d(req_tgl), .q(req_s));
  tcs_sync2 u_clr_sync (.clk(per_clk), .rst_n(per_rst_n), .d(clr_tgl), .q(clr_s));
  tcs_sync2 u_ack_sync (.clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_tgl), .q(ack_s));

  tcs_counter #(.DW(DW)) u_cnt (
    .clk       (per_clk),
    .rst_n     (per_rst_n),
    .md        (md),
    .cnt_en    (cnt_en),
    .start     (start),
    .hit       (hit),
    .cnt       (count),
    .tick      (tick),
    .reload_pt (reload_pt)
  );

  tcs_cmp_unit #(.DW(DW), .RST_CMP(RST_CMP)) u_cmp (
    .clk       (per_clk),
    .rst_n     (per_rst_n),
    .md        (md),
    .stage     (stage),
    .req_s     (req_s),
    .clr_s     (clr_s),
    .cnt       (count),
    .tick      (tick),
    .reload_pt (reload_pt),
    .active    (cmp_cur),
    .hit       (hit),
    .flag      (match_flag),
    .ack_tgl   (ack_tgl)
  );
endmodule

// File: tb/tmr_cmp_sync_tb_top.sv
module tmr_cmp_sync_tb_top;
  localparam int CPU_PERIOD = 100;
  localparam int PER_HALF_SLOW = 65;
  localparam int PER_HALF_FAST = 35;

  int per_half = PER_HALF_SLOW;

  logic        cpu_clk, cpu_rst_n, cmp_wr, flag_clr, bus_wait;
  logic [15:0] cmp_wdata;
  logic        per_clk, per_rst_n, cnt_en, start, match_flag;
  logic [2:0]  mode;
  logic [15:0] count, cmp_cur;

  int n_chk = 0;
  int n_fail = 0;

  tmr_cmp_sync dut_i (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .bus_wait(bus_wait), .per_clk(per_clk), .per_rst_n(per_rst_n),
    .mode(mode), .cnt_en(cnt_en), .start(start), .count(count), .cmp_cur(cmp_cur),
    .match_flag(match_flag)
  );

  initial begin
    cpu_clk = 1'b0;
    forever #(CPU_PERIOD / 2) cpu_clk = ~cpu_clk;
  end

  initial begin
    per_clk = 1'b0;
    #3;
    forever #(per_half) per_clk = ~per_clk;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    cpu_rst_n = 1'b0;
    per_rst_n = 1'b0;
    cmp_wr    = 1'b0;
    cmp_wdata = '0;
    flag_clr  = 1'b0;
    cnt_en    = 1'b0;
    start     = 1'b0;
    mode      = m;
    repeat (3) @(posedge cpu_clk);
    @(negedge cpu_clk) cpu_rst_n = 1'b1;
    @(negedge per_clk) per_rst_n = 1'b1;
    repeat (2) @(negedge cpu_clk);
  endtask

  // Returns at the bus negedge after the accepting edge.
  task automatic cpu_write(input logic [15:0] v, output int waits);
    @(negedge cpu_clk);
    cmp_wr    = 1'b1;
    cmp_wdata = v;
    waits     = 0;
    forever begin
      #1;
      if (!bus_wait) break;
      waits++;
      @(negedge cpu_clk);
    end
    @(posedge cpu_clk);
    @(negedge cpu_clk);
    cmp_wr = 1'b0;
  endtask

  task automatic wait_cur(input logic [15:0] v, output int lat);
    lat = 1;
    while (cmp_cur !== v && lat < 400) begin
      @(negedge cpu_clk);
      lat++;
    end
  endtask

  task automatic per_ticks(input int n);
    @(negedge per_clk) cnt_en = 1'b1;
    repeat (n) @(negedge per_clk);
    cnt_en = 1'b0;
  endtask

  task automatic cpu_clear();
    @(negedge cpu_clk) flag_clr = 1'b1;
    @(negedge cpu_clk) flag_clr = 1'b0;
    repeat (8) @(negedge cpu_clk);
  endtask

  task automatic t_reset();
    do_reset(3'd0);
    check_eq("R1 count", count, 0);
    check_eq("R1 operand", cmp_cur, 16'hFFFF);
    check_eq("R1 flag", match_flag, 0);
    check_eq("R1 wait", bus_wait, 0);
  endtask

  task automatic t_free_count();
    do_reset(3'd0);
    per_ticks(5);
    check_eq("R2 five ticks", count, 5);
    repeat (6) @(negedge per_clk);
    check_eq("R2 hold when disabled", count, 5);
  endtask

  task automatic t_latency(input int half, input logic [15:0] v);
    int  w, lat;
    real bound;
    per_half = half;
    do_reset(3'd0);
    bound = 4.0 * real'(2 * half) / real'(CPU_PERIOD) + 3.0;
    cpu_write(v, w);
    wait_cur(v, lat);
    check_eq("R3 operand value", cmp_cur, v);
    check_true("R3 takeover latency", real'(lat) <= bound, lat, int'(bound));
  endtask

  task automatic t_old_match();
    int w, lat;
    per_half = PER_HALF_SLOW;
    do_reset(3'd1);
    cpu_write(16'd5, w);
    wait_cur(16'd5, lat);
    per_ticks(5);
    check_eq("R7 count at old operand", count, 5);
    check_eq("R7 no flag yet", match_flag, 0);
    cpu_write(16'd9, w);
    per_ticks(1);
    check_eq("R7 old operand match during handoff", match_flag, 1);
    check_eq("R7 count after tick", count, 6);
    wait_cur(16'd9, lat);
    per_ticks(3);
    cpu_clear();
    check_eq("R8 flag cleared", match_flag, 0);
    per_ticks(1);
    check_eq("R7 new operand match", match_flag, 1);
    check_eq("R7 count", count, 10);
  endtask

  task automatic t_back_to_back();
    int w1, w2, lat;
    per_half = PER_HALF_SLOW;
    do_reset(3'd0);
    cpu_write(16'h00AA, w1);
    cpu_write(16'h00BB, w2);
    check_true("R9 second write stalled", w2 > 0, w2, 1);
    wait_cur(16'h00BB, lat);
    check_eq("R9 held write takes effect", cmp_cur, 16'h00BB);
    check_eq("R9 wait released", bus_wait, 0);
  endtask

  task automatic t_reload(input logic [2:0] m);
    int w;
    per_half = PER_HALF_FAST;
    do_reset(m);
    cpu_write(16'd3, w);
    repeat (30) @(negedge cpu_clk);
    check_eq("R4 operand held before reload point", cmp_cur, 16'hFFFF);
    per_ticks(4);
    check_eq("R4 counting continues", count, 4);
    check_eq("R4 operand still held", cmp_cur, 16'hFFFF);
    if (m == 3'd5) begin
      @(negedge per_clk) start = 1'b1;
      @(negedge per_clk) start = 1'b0;
      check_eq("R10 trigger restart", count, 0);
      check_eq("R4 operand loaded at restart", cmp_cur, 16'd3);
    end
  endtask

  task automatic t_interval();
    int w, lat;
    per_half = PER_HALF_SLOW;
    do_reset(3'd3);
    cpu_write(16'd4, w);
    wait_cur(16'd4, lat);
    per_ticks(7);
    check_eq("R5 interval wrap", count, 2);
    check_eq("R5 match flag", match_flag, 1);
  endtask

  task automatic t_oneshot();
    int w, lat;
    per_half = PER_HALF_FAST;
    do_reset(3'd2);
    cpu_write(16'd3, w);
    wait_cur(16'd3, lat);
    per_ticks(4);
    check_eq("R6 idle before start", count, 0);
    @(negedge per_clk) begin start = 1'b1; cnt_en = 1'b1; end
    @(negedge per_clk) start = 1'b0;
    repeat (2) @(negedge per_clk);
    check_eq("R6 counting after start", count, 2);
    repeat (10) @(negedge per_clk);
    cnt_en = 1'b0;
    check_eq("R6 halted at zero", count, 0);
    check_eq("R6 match flag", match_flag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_free_count();
    t_latency(PER_HALF_SLOW, 16'h1234);
    t_latency(PER_HALF_FAST, 16'hBEEF);
    t_old_match();
    t_back_to_back();
    t_reload(3'd5);
    t_reload(3'd4);
    t_interval();
    t_oneshot();
    summary();
    $finish;
  end
endmodule